// File: doc/BRIEF.md
# Timer Output Waveform Unit

This block turns compare events from a timer channel into one registered output pin level. It takes two single-cycle strobes. The first is the channel's own equality match. The second is the period match, which marks the boundary of the counter period. A 3-bit mode field chooses how each strobe acts on the pin: set it, clear it, toggle it, or leave it alone. Pairing a first action on the own match with a second action on the period match produces edge-aligned or centre-aligned PWM waveforms without software involvement.

In mode 0 the pin copies a software-written level instead. The counter and the comparators sit outside this block. The parameter `PERIOD_CH` builds the variant used on the channel that defines the period. In that variant the own match also serves as the period match, so the separate period input has no effect.

Top module: `tmr_out_unit`

## Requirements
- R1: While rst_ni is low, out_o is 0, and it stays 0 after reset is released until a mode action changes it.
- R2: With mode_i = 3'b000, out_o takes the value of sw_out_i at the next rising clock edge, whatever the strobes do.
- R3: With mode_i = 3'b001, an own match (eq_own_i = 1) drives out_o to 1. With mode_i = 3'b101, an own match drives out_o to 0.
- R4: With mode_i = 3'b100, each own match inverts out_o at the next edge.
- R5: The paired modes apply their first action on the own match and their second action on the period match (eq_per_i = 1). The pairs are: 3'b010 toggle then clear, 3'b011 set then clear, 3'b110 toggle then set, and 3'b111 clear then set.
- R6: In modes 3'b001, 3'b100 and 3'b101 the period match alone leaves out_o unchanged.
- R7: When both strobes are high in the same cycle in a paired mode, only the own-match action is applied.
- R8: In any nonzero mode, a cycle with neither strobe high leaves out_o unchanged.
- R9: A new mode_i value governs the very next clock edge. There is no extra latency and no pending state from the previous mode.
- R10: With PERIOD_CH = 1, eq_per_i has no effect. In paired modes only the own-match action occurs, for example a toggle in mode 3'b010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Output mode select |
| sw_out_i | input | 1 | Software level used in mode 0 |
| eq_own_i | input | 1 | Own-channel equality strobe |
| eq_per_i | input | 1 | Period-boundary equality strobe |
| out_o | output | 1 | Registered output pin level |

## Verification
The assertions assume that mode_i, sw_out_i and both strobes are known, synchronous values from the first edge after reset. They also assume that each strobe is a level sampled once per edge, not a pulse that needs edge detection. The bench meets this by changing every input only on the falling clock edge. It drives defined values from time zero and holds each strobe high for exactly one sampled edge. Simultaneous strobes appear only in the priority scenarios.

// File: rtl/tmr_out_pkg.sv
package tmr_out_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_SW      = 3'd0,
    MODE_SET     = 3'd1,
    MODE_TOG_CLR = 3'd2,
    MODE_SET_CLR = 3'd3,
    MODE_TOG     = 3'd4,
    MODE_CLR     = 3'd5,
    MODE_TOG_SET = 3'd6,
    MODE_CLR_SET = 3'd7
  } mode_e;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_SET,
    ACT_CLR,
    ACT_TOG,
    ACT_SW
  } act_e;
endpackage

// File: rtl/tmr_out_decode.sv
module tmr_out_decode
  import tmr_out_pkg::*;
(
  input  mode_e mode_i,
  input  logic  own_i,
  input  logic  per_i,
  output act_e  act_o
);
  act_e own_act, per_act;

  always_comb begin
    own_act = ACT_HOLD;
    per_act = ACT_HOLD;
    unique case (mode_i)
      MODE_SW:      begin own_act = ACT_SW;  per_act = ACT_SW;   end
      MODE_SET:     own_act = ACT_SET;
      MODE_TOG_CLR: begin own_act = ACT_TOG; per_act = ACT_CLR;  end
      MODE_SET_CLR: begin own_act = ACT_SET; per_act = ACT_CLR;  end
      MODE_TOG:     own_act = ACT_TOG;
      MODE_CLR:     own_act = ACT_CLR;
      MODE_TOG_SET: begin own_act = ACT_TOG; per_act = ACT_SET;  end
      MODE_CLR_SET: begin own_act = ACT_CLR; per_act = ACT_SET;  end
      default:      ;
    endcase
  end

  // software mode ignores strobes; own match outranks period match
  always_comb begin
    if (mode_i == MODE_SW) act_o = ACT_SW;
    else if (own_i)        act_o = own_act;
    else if (per_i)        act_o = per_act;
    else                   act_o = ACT_HOLD;
  end
endmodule

// File: rtl/tmr_out_reg.sv
module tmr_out_reg
  import tmr_out_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  act_e act_i,
  input  logic sw_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    unique case (act_i)
      ACT_SET: q_d = 1'b1;
      ACT_CLR: q_d = 1'b0;
      ACT_TOG: q_d = ~q_o;
      ACT_SW:  q_d = sw_i;
      default: q_d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end

  a_r8_hold_no_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_HOLD |=> $stable(q_o));
endmodule

// File: rtl/tmr_out_unit.sv
module tmr_out_unit
  import tmr_out_pkg::*;
#(
  parameter bit PERIOD_CH = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              sw_out_i,
  input  logic              eq_own_i,
  input  logic              eq_per_i,
  output logic              out_o
);
  mode_e mode;
  logic  per_eff;
  act_e  act;

  assign mode = mode_e'(mode_i);

  generate
    if (PERIOD_CH) begin : g_per_from_own
      assign per_eff = eq_own_i;  // R10: own match doubles as period match
    end else begin : g_per_ext
      assign per_eff = eq_per_i;
    end
  endgenerate

  tmr_out_decode u_decode (
    .mode_i (mode),
    .own_i  (eq_own_i),
    .per_i  (per_eff),
    .act_o  (act)
  );

  tmr_out_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .sw_i   (sw_out_i),
    .q_o    (out_o)
  );

  a_r2_sw_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 3'd0 |=> out_o == $past(sw_out_i));

  a_r4_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd4 && eq_own_i) |=> out_o != $past(out_o));

  a_r6_clr_ignores_per: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd5 && !eq_own_i) |=> $stable(out_o));

  a_r7_own_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd3 && eq_own_i) |=> out_o);

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 3'd0 && !eq_own_i && !eq_per_i) |=> $stable(out_o));
endmodule

// File: tb/tmr_out_unit_tb.sv
`timescale 1ns/1ps
module tmr_out_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic sw = 1'b0, own = 1'b0, per = 1'b0;
  logic [2:0] c_mode = 3'd0;
  logic c_sw = 1'b0, c_own = 1'b0, c_per = 1'b0;
  logic out, c_out;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_out_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sw_out_i(sw),
    .eq_own_i(own), .eq_per_i(per), .out_o(out)
  );

  tmr_out_unit #(.PERIOD_CH(1'b1)) u_dut_c0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(c_mode), .sw_out_i(c_sw),
    .eq_own_i(c_own), .eq_per_i(c_per), .out_o(c_out)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: out=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // drive on falling edge, sample 1 ns after the following rising edge
  task automatic cyc(input logic [2:0] m, input logic s, input logic o, input logic p);
    @(negedge clk);
    mode = m; sw = s; own = o; per = p;
    @(posedge clk); #1;
    @(negedge clk);
    own = 1'b0; per = 1'b0;
  endtask

  task automatic ccyc(input logic [2:0] m, input logic s, input logic o, input logic p);
    @(negedge clk);
    c_mode = m; c_sw = s; c_own = o; c_per = p;
    @(posedge clk); #1;
    @(negedge clk);
    c_own = 1'b0; c_per = 1'b0;
  endtask

  task automatic t_reset;
    check(out, 1'b0, "R1 in reset");
    check(c_out, 1'b0, "R1 in reset c0");
    @(negedge clk); rst_n = 1'b1;
    cyc(3'd1, 1'b1, 1'b0, 1'b0);
    check(out, 1'b0, "R1 after release");
  endtask

  task automatic t_sw;
    cyc(3'd0, 1'b1, 1'b0, 1'b0); check(out, 1'b1, "R2 sw=1");
    cyc(3'd0, 1'b0, 1'b1, 1'b1); check(out, 1'b0, "R2 sw=0 strobes ignored");
  endtask

  task automatic t_single;
    cyc(3'd1, 1'b0, 1'b0, 1'b1); check(out, 1'b0, "R6 set mode period only");
    cyc(3'd1, 1'b0, 1'b1, 1'b0); check(out, 1'b1, "R3 set on own");
    cyc(3'd5, 1'b0, 1'b0, 1'b1); check(out, 1'b1, "R6 clear mode period only");
    cyc(3'd5, 1'b0, 1'b1, 1'b0); check(out, 1'b0, "R3 clear on own");
    cyc(3'd4, 1'b0, 1'b1, 1'b0); check(out, 1'b1, "R4 toggle up");
    cyc(3'd4, 1'b0, 1'b0, 1'b1); check(out, 1'b1, "R6 toggle mode period only");
    cyc(3'd4, 1'b0, 1'b0, 1'b0); check(out, 1'b1, "R8 idle hold");
    cyc(3'd4, 1'b0, 1'b1, 1'b0); check(out, 1'b0, "R4 toggle down");
  endtask

  task automatic t_paired;
    cyc(3'd2, 1'b0, 1'b1, 1'b0); check(out, 1'b1, "R5 tog/clr own");
    cyc(3'd2, 1'b0, 1'b0, 1'b1); check(out, 1'b0, "R5 tog/clr period");
    cyc(3'd3, 1'b0, 1'b1, 1'b0); check(out, 1'b1, "R5 set/clr own");
    cyc(3'd3, 1'b0, 1'b0, 1'b0); check(out, 1'b1, "R8 set/clr idle");
    cyc(3'd3, 1'b0, 1'b0, 1'b1); check(out, 1'b0, "R5 set/clr period");
    cyc(3'd6, 1'b0, 1'b1, 1'b0); check(out, 1'b1, "R5 tog/set own up");
    cyc(3'd6, 1'b0, 1'b1, 1'b0); check(out, 1'b0, "R5 tog/set own down");
    cyc(3'd6, 1'b0, 1'b0, 1'b1); check(out, 1'b1, "R5 tog/set period");
    cyc(3'd7, 1'b0, 1'b1, 1'b0); check(out, 1'b0, "R5 clr/set own");
    cyc(3'd7, 1'b0, 1'b0, 1'b1); check(out, 1'b1, "R5 clr/set period");
  endtask

  task automatic t_prio;
    cyc(3'd7, 1'b0, 1'b1, 1'b1); check(out, 1'b0, "R7 clr/set both");
    cyc(3'd3, 1'b0, 1'b1, 1'b1); check(out, 1'b1, "R7 set/clr both");
    cyc(3'd2, 1'b0, 1'b1, 1'b1); check(out, 1'b0, "R7 tog/clr both");
    cyc(3'd6, 1'b0, 1'b1, 1'b1); check(out, 1'b1, "R7 tog/set both");
  endtask

  task automatic t_mode_change;
    cyc(3'd0, 1'b0, 1'b0, 1'b0); check(out, 1'b0, "R9 to sw mode");
    cyc(3'd0, 1'b1, 1'b0, 1'b0); check(out, 1'b1, "R9 sw high");
    cyc(3'd5, 1'b0, 1'b0, 1'b0); check(out, 1'b1, "R9 leave sw mode, hold");
    cyc(3'd2, 1'b0, 1'b0, 1'b1); check(out, 1'b0, "R9 new mode first edge");
  endtask

  task automatic t_ch0;
    ccyc(3'd0, 1'b0, 1'b0, 1'b0); check(c_out, 1'b0, "R10 c0 start");
    ccyc(3'd2, 1'b0, 1'b0, 1'b1); check(c_out, 1'b0, "R10 c0 period ignored");
    ccyc(3'd2, 1'b0, 1'b1, 1'b0); check(c_out, 1'b1, "R10 c0 tog/clr toggles");
    ccyc(3'd2, 1'b0, 1'b1, 1'b0); check(c_out, 1'b0, "R10 c0 toggles again");
    ccyc(3'd6, 1'b0, 1'b0, 1'b1); check(c_out, 1'b0, "R10 c0 tog/set period ignored");
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_sw();
    t_single();
    t_paired();
    t_prio();
    t_mode_change();
    t_ch0();
    done = 1'b1;
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_up();
    end
  end
endmodule